// File: doc/BRIEF.md
# Vector Loop Element-Step Sequencer

This block holds the state word of a vector loop and walks the element and subvector counters through that loop. The state word keeps a maximum length, a vector length, a source and a destination element step, a source and a destination subvector step, a subvector group code, and four mode bits: vertical, source-swap, destination-swap and remap-keep. The execution pipeline sends one issue strobe per instruction. In horizontal mode each issue moves the counters forward by one position. In vertical mode the counters stay where they are until an explicit step command arrives.

Each side, source and destination, runs a two-level nested loop. By default the subvector step is the inner loop and the element step is the outer loop. A per-side swap bit inverts that order. A set-length command loads the maximum length from an immediate and clamps the requested length to it. A plain whole-word write port and read port allow context save and restore. Writes and commands that would put a length above 64 or a step at 64 or more are rejected, and an illegal flag is raised instead.

Top module: `vlseq_top`

## Requirements
- R1: A synchronous active-high reset clears every field of the state word, and the loop_end and illegal outputs are 0.
- R2: With set_en and no write, and set_max <= 64, the next state has the maximum length equal to set_max and the vector length equal to min(set_req, set_max). All other fields are unchanged.
- R3: A set-length command clears the remap-keep bit when it changes the vector length or the maximum length. Otherwise the bit keeps its value.
- R4: Some commands are rejected: a write whose source or destination step is 64 or more, or whose vector length or maximum length exceeds 64, and a set-length with set_max > 64. A rejected command drives illegal to 1 for one cycle on the following cycle and leaves the state word unchanged.
- R5: An advance event is an issue strobe in horizontal mode (vertical bit 0). On each advance event, each side whose swap bit is 0 increments its subvector step. When the subvector step reaches the group code, it wraps to 0 and the element step increments instead. Group codes 0..3 mean groups of 1..4.
- R6: The source-swap bit inverts the source-side nesting, and the destination-swap bit inverts the destination-side nesting. With a side's swap bit set, the element step is the inner loop and wraps after vector length - 1, and the subvector step then increments.
- R7: With the vertical bit set, an issue strobe leaves every step unchanged, and a step command is the advance event. With the vertical bit clear, a step command without issue has no effect.
- R8: On an advance event where the source element step >= vector length - 1 and the source subvector step >= the group code, loop_end is 1 for the next cycle only and all four steps become 0.
- R9: On an advance event with vector length 0, loop_end is 1 for the next cycle and all steps are 0.
- R10: A write (wr_en) loads the whole state word in one cycle and takes priority over a simultaneous set-length, issue or step. The word layout, MSB first, is: maximum length [37:31], vector length [30:24], source step [23:17], destination step [16:10], source subvector [9:8], destination subvector [7:6], group code [5:4], vertical [3], source-swap [2], destination-swap [1], remap-keep [0]. rd_state shows the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Whole-word state write |
| wr_state | input | 38 | State word to write |
| set_en | input | 1 | Set-length command |
| set_max | input | 7 | Immediate maximum length |
| set_req | input | 7 | Requested vector length |
| issue | input | 1 | Per-instruction issue strobe |
| step | input | 1 | Explicit step command |
| rd_state | output | 38 | Current state word |
| src_elem | output | 7 | Source element step |
| src_sub | output | 2 | Source subvector step |
| dst_elem | output | 7 | Destination element step |
| dst_sub | output | 2 | Destination subvector step |
| loop_end | output | 1 | One-cycle end-of-loop pulse |
| illegal | output | 1 | One-cycle rejected-command pulse |

## Verification
The advance logic is driven under four conditions:
- Both swap bits clear, which confirms the subvector-inner order.
- Source swap only, and destination swap only, which shows that the two sides nest independently.
- Each group code, which separates the off-by-one cases of the subvector wrap.
- Steps written above the vector length, which exercises the element-wrap comparison rather than equality.

Vertical mode is tested with issue and step separately and together, which confirms which strobe moves the counters. Vector length 0, a clamped request and a rejected write each target one boundary. Long random mixes of writes, set-length commands, issues and steps check the command priority against a bench model.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;
    localparam int STEP_W     = 7;
    localparam int SUB_W      = 2;
    localparam int STEP_LIMIT = 64;
    localparam int LEN_LIMIT  = 64;

    typedef struct packed {
        logic [STEP_W-1:0] maxlen;
        logic [STEP_W-1:0] veclen;
        logic [STEP_W-1:0] src_step;
        logic [STEP_W-1:0] dst_step;
        logic [SUB_W-1:0]  src_sub;
        logic [SUB_W-1:0]  dst_sub;
        logic [SUB_W-1:0]  grp;
        logic              vert;
        logic              src_swap;
        logic              dst_swap;
        logic              keep;
    } loop_state_t;

    localparam int STATE_W = $bits(loop_state_t);

    typedef struct packed {
        loop_state_t st;
        logic        fin;
        logic        bad;
    } seq_regs_t;
endpackage

// File: rtl/vlseq_side.sv
// One side (source or destination) of the nested element/subvector loop.
module vlseq_side #(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2
) (
    input  logic [STEP_W-1:0] elem,
    input  logic [SUB_W-1:0]  sub,
    input  logic [STEP_W-1:0] veclen,
    input  logic [SUB_W-1:0]  grp,
    input  logic              swap,
    output logic [STEP_W-1:0] elem_nx,
    output logic [SUB_W-1:0]  sub_nx,
    output logic              at_end
);
    localparam int WIDE = STEP_W + 1;

    logic elem_last;
    logic sub_last;

    always_comb begin
        elem_last = (veclen == '0) ||
                    ((WIDE'(elem) + WIDE'(1)) >= WIDE'(veclen));
        sub_last  = (sub >= grp);
        at_end    = elem_last && sub_last;
        elem_nx   = elem;
        sub_nx    = sub;
        if (!swap) begin
            if (sub_last) begin
                sub_nx  = '0;
                elem_nx = elem_last ? '0 : elem + STEP_W'(1);
            end else begin
                sub_nx = sub + SUB_W'(1);
            end
        end else begin
            if (elem_last) begin
                elem_nx = '0;
                sub_nx  = sub_last ? '0 : sub + SUB_W'(1);
            end else begin
                elem_nx = elem + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/vlseq_legal.sv
// Range check of a whole state word offered on the write port.
module vlseq_legal
    import vlseq_pkg::*;
(
    input  loop_state_t cand,
    output logic        ok
);
    always_comb begin
        ok = (int'(cand.src_step) < STEP_LIMIT) &&
             (int'(cand.dst_step) < STEP_LIMIT) &&
             (int'(cand.veclen)   <= LEN_LIMIT) &&
             (int'(cand.maxlen)   <= LEN_LIMIT);
    end
endmodule

// File: rtl/vlseq_len.sv
// Set-length evaluation: clamp, range check and remap-keep clearing.
module vlseq_len
    import vlseq_pkg::*;
(
    input  loop_state_t       cur,
    input  logic [STEP_W-1:0] imm_max,
    input  logic [STEP_W-1:0] req,
    output loop_state_t       upd,
    output logic              bad
);
    logic [STEP_W-1:0] new_len;

    always_comb begin
        bad     = int'(imm_max) > LEN_LIMIT;
        new_len = (req < imm_max) ? req : imm_max;
        upd     = cur;
        upd.maxlen = imm_max;
        upd.veclen = new_len;
        if ((new_len != cur.veclen) || (imm_max != cur.maxlen))
            upd.keep = 1'b0;
    end
endmodule

// File: rtl/vlseq_top.sv
module vlseq_top
    import vlseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_state,
    input  logic               set_en,
    input  logic [STEP_W-1:0]  set_max,
    input  logic [STEP_W-1:0]  set_req,
    input  logic               issue,
    input  logic               step,
    output logic [STATE_W-1:0] rd_state,
    output logic [STEP_W-1:0]  src_elem,
    output logic [SUB_W-1:0]   src_sub,
    output logic [STEP_W-1:0]  dst_elem,
    output logic [SUB_W-1:0]   dst_sub,
    output logic               loop_end,
    output logic               illegal
);
    localparam int SIDES = 2;

    seq_regs_t   regs_d, regs_q;
    loop_state_t wr_in;
    loop_state_t len_st;
    logic        wr_ok;
    logic        len_bad;
    logic        adv;

    logic [STEP_W-1:0] side_elem    [SIDES];
    logic [SUB_W-1:0]  side_sub     [SIDES];
    logic              side_swap    [SIDES];
    logic [STEP_W-1:0] side_elem_nx [SIDES];
    logic [SUB_W-1:0]  side_sub_nx  [SIDES];
    logic              side_end     [SIDES];

    assign wr_in = loop_state_t'(wr_state);

    vlseq_legal u_legal (
        .cand (wr_in),
        .ok   (wr_ok)
    );

    vlseq_len u_len (
        .cur     (regs_q.st),
        .imm_max (set_max),
        .req     (set_req),
        .upd     (len_st),
        .bad     (len_bad)
    );

    // side 0 = source, side 1 = destination
    assign side_elem[0] = regs_q.st.src_step;
    assign side_sub[0]  = regs_q.st.src_sub;
    assign side_swap[0] = regs_q.st.src_swap;
    assign side_elem[1] = regs_q.st.dst_step;
    assign side_sub[1]  = regs_q.st.dst_sub;
    assign side_swap[1] = regs_q.st.dst_swap;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        vlseq_side #(
            .STEP_W (STEP_W),
            .SUB_W  (SUB_W)
        ) u_side (
            .elem    (side_elem[g]),
            .sub     (side_sub[g]),
            .veclen  (regs_q.st.veclen),
            .grp     (regs_q.st.grp),
            .swap    (side_swap[g]),
            .elem_nx (side_elem_nx[g]),
            .sub_nx  (side_sub_nx[g]),
            .at_end  (side_end[g])
        );
    end

    always_comb begin
        adv        = regs_q.st.vert ? step : issue;
        regs_d     = regs_q;
        regs_d.fin = 1'b0;
        regs_d.bad = 1'b0;
        if (wr_en) begin
            if (wr_ok) regs_d.st  = wr_in;
            else       regs_d.bad = 1'b1;
        end else if (set_en) begin
            if (len_bad) regs_d.bad = 1'b1;
            else         regs_d.st  = len_st;
        end else if (adv) begin
            if (side_end[0] || (regs_q.st.veclen == '0)) begin
                regs_d.fin         = 1'b1;
                regs_d.st.src_step = '0;
                regs_d.st.dst_step = '0;
                regs_d.st.src_sub  = '0;
                regs_d.st.dst_sub  = '0;
            end else begin
                regs_d.st.src_step = side_elem_nx[0];
                regs_d.st.src_sub  = side_sub_nx[0];
                regs_d.st.dst_step = side_elem_nx[1];
                regs_d.st.dst_sub  = side_sub_nx[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign rd_state = regs_q.st;
    assign src_elem = regs_q.st.src_step;
    assign src_sub  = regs_q.st.src_sub;
    assign dst_elem = regs_q.st.dst_step;
    assign dst_sub  = regs_q.st.dst_sub;
    assign loop_end = regs_q.fin;
    assign illegal  = regs_q.bad;

    // R4: lengths and steps never leave their legal range
    a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        (int'(regs_q.st.maxlen) <= LEN_LIMIT) && (int'(regs_q.st.veclen) <= LEN_LIMIT) &&
        (int'(regs_q.st.src_step) < STEP_LIMIT) && (int'(regs_q.st.dst_step) < STEP_LIMIT));

    // R4: a rejected command leaves the state word untouched
    a_r4_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || !wr_ok) && (wr_en || !set_en || len_bad) && (wr_en || set_en) |=>
        (illegal && $stable(rd_state)));

    // R2: a legal set-length never leaves the length above the maximum
    a_r2_clamped: assert property (@(posedge clk) disable iff (rst)
        (set_en && !wr_en && (int'(set_max) <= LEN_LIMIT)) |=>
        (regs_q.st.veclen <= regs_q.st.maxlen));

    // R7: in vertical mode, no step command means no movement
    a_r7_vert_hold: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st.vert && !step && !wr_en) |=>
        ($stable(src_elem) && $stable(dst_elem) && $stable(src_sub) && $stable(dst_sub)));

    // R9: an advance with an empty vector ends the loop at once
    a_r9_empty_ends: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !set_en && (regs_q.st.veclen == '0) &&
         (regs_q.st.vert ? step : issue)) |=> loop_end);

    // R8: the end pulse always comes with all steps back at zero
    a_r8_steps_zero: assert property (@(posedge clk) disable iff (rst)
        loop_end |-> (src_elem == '0 && dst_elem == '0 && src_sub == '0 && dst_sub == '0));
endmodule

// File: tb/vlseq_top_test.sv
`timescale 1ns/1ps
module vlseq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [37:0] wr_state = '0;
    logic        set_en = 1'b0;
    logic [6:0]  set_max = '0;
    logic [6:0]  set_req = '0;
    logic        issue = 1'b0;
    logic        step = 1'b0;
    logic [37:0] rd_state;
    logic [6:0]  src_elem, dst_elem;
    logic [1:0]  src_sub, dst_sub;
    logic        loop_end, illegal;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vlseq_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_state(wr_state),
        .set_en(set_en), .set_max(set_max), .set_req(set_req),
        .issue(issue), .step(step), .rd_state(rd_state),
        .src_elem(src_elem), .src_sub(src_sub), .dst_elem(dst_elem),
        .dst_sub(dst_sub), .loop_end(loop_end), .illegal(illegal)
    );

    // bench model
    int m_mx, m_vl, m_ss, m_ds, m_ssb, m_dsb, m_gp, m_vf, m_pk, m_up, m_kp;
    bit m_end, m_ill;
    string tag;

    function automatic logic [37:0] mk(int mx, int vl, int ss, int ds, int ssb,
                                       int dsb, int gp, int vf, int pk, int up, int kp);
        return {7'(mx), 7'(vl), 7'(ss), 7'(ds), 2'(ssb), 2'(dsb), 2'(gp),
                1'(vf), 1'(pk), 1'(up), 1'(kp)};
    endfunction

    function automatic void side_adv(inout int e, inout int s, input int sw, input int vl, input int gp);
        bit el = (e + 1 >= vl);
        bit sl = (s >= gp);
        if (sw == 0) begin
            if (sl) begin s = 0; e = el ? 0 : e + 1; end
            else s = s + 1;
        end else begin
            if (el) begin e = 0; s = sl ? 0 : s + 1; end
            else e = e + 1;
        end
    endfunction

    task automatic model_step();
        int nv;
        bit a;
        m_end = 0; m_ill = 0;
        if (rst) begin
            {m_mx, m_vl, m_ss, m_ds, m_ssb, m_dsb, m_gp, m_vf, m_pk, m_up, m_kp} = '0;
            tag = "R1";
        end else if (wr_en) begin
            if (wr_state[23:17] >= 64 || wr_state[16:10] >= 64 ||
                wr_state[30:24] > 64 || wr_state[37:31] > 64) begin
                m_ill = 1; tag = "R4";
            end else begin
                m_mx = wr_state[37:31]; m_vl = wr_state[30:24];
                m_ss = wr_state[23:17]; m_ds = wr_state[16:10];
                m_ssb = wr_state[9:8]; m_dsb = wr_state[7:6]; m_gp = wr_state[5:4];
                m_vf = wr_state[3]; m_pk = wr_state[2]; m_up = wr_state[1]; m_kp = wr_state[0];
                tag = "R10";
            end
        end else if (set_en) begin
            if (set_max > 64) begin
                m_ill = 1; tag = "R4";
            end else begin
                nv = (set_req < set_max) ? int'(set_req) : int'(set_max);
                if (nv != m_vl || int'(set_max) != m_mx) m_kp = 0;
                tag = (m_kp == 0) ? "R3" : "R2";
                m_mx = set_max; m_vl = nv;
            end
        end else begin
            a = (m_vf != 0) ? step : issue;
            tag = (m_vf != 0) ? "R7" : "R5";
            if (a) begin
                if (m_vl == 0) begin
                    m_end = 1; m_ss = 0; m_ds = 0; m_ssb = 0; m_dsb = 0; tag = "R9";
                end else if (m_ss + 1 >= m_vl && m_ssb >= m_gp) begin
                    m_end = 1; m_ss = 0; m_ds = 0; m_ssb = 0; m_dsb = 0; tag = "R8";
                end else begin
                    side_adv(m_ss, m_ssb, m_pk, m_vl, m_gp);
                    side_adv(m_ds, m_dsb, m_up, m_vl, m_gp);
                    if (m_pk != 0 || m_up != 0) tag = "R6";
                end
            end
        end
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run();
        @(posedge clk);
        model_step();
        #1;
        chk("state", 64'(rd_state),
            64'(mk(m_mx, m_vl, m_ss, m_ds, m_ssb, m_dsb, m_gp, m_vf, m_pk, m_up, m_kp)));
        chk("src_elem", 64'(src_elem), 64'(m_ss));
        chk("dst_sub", 64'(dst_sub), 64'(m_dsb));
        chk("loop_end", 64'(loop_end), 64'(m_end));
        chk("illegal", 64'(illegal), 64'(m_ill));
        wr_en = 0; set_en = 0; issue = 0; step = 0;
    endtask

    task automatic wr(logic [37:0] v);
        wr_en = 1; wr_state = v; run();
    endtask

    task automatic setl(int mx, int rq);
        set_en = 1; set_max = 7'(mx); set_req = 7'(rq); run();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1; run(); run();                       // R1 reset state
        rst = 0;
        setl(10, 20);                                // R2 clamp to maximum
        setl(10, 3);                                 // R2 request below maximum
        wr(mk(10, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1));   // R10 write with keep
        setl(10, 3);                                 // R3 unchanged: keep stays
        setl(10, 5);                                 // R3 changed: keep clears
        wr(mk(10, 3, 64, 0, 0, 0, 0, 0, 0, 0, 0));  // R4 step too large
        wr(mk(65, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0));   // R4 maximum too large
        setl(70, 2);                                 // R4 set-length rejected
        wr(mk(8, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0));    // R5 groups of 2
        for (int i = 0; i < 5; i++) begin issue = 1; run(); end   // R5, R8
        step = 1; run();                             // R7 step ignored horizontally
        wr(mk(8, 3, 0, 0, 0, 0, 2, 0, 1, 0, 0));    // R6 source swap
        for (int i = 0; i < 10; i++) begin issue = 1; run(); end
        wr(mk(8, 3, 0, 0, 0, 0, 3, 0, 0, 1, 0));    // R6 destination swap
        for (int i = 0; i < 13; i++) begin issue = 1; run(); end
        wr(mk(8, 4, 0, 0, 0, 0, 0, 1, 0, 0, 0));    // R7 vertical mode
        issue = 1; run();
        step = 1; run();
        issue = 1; step = 1; run();
        wr(mk(8, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0));    // R9 empty vector
        issue = 1; run();
        wr(mk(8, 3, 50, 50, 0, 0, 0, 0, 0, 0, 0));  // R8 steps above length wrap
        issue = 1; run();
        wr_en = 1; wr_state = mk(9, 9, 1, 2, 0, 0, 1, 0, 0, 0, 1);
        set_en = 1; set_max = 7'd4; set_req = 7'd4; issue = 1; run();  // R10 priority
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            if (r < 4) begin
                wr_en = 1;
                wr_state = mk($urandom % 70, $urandom % 12, $urandom % 66, $urandom % 66,
                              $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 2,
                              $urandom % 2, $urandom % 2, $urandom % 2);
            end else if (r < 10) begin
                set_en = 1; set_max = 7'($urandom % 72); set_req = 7'($urandom % 128);
            end
            issue = ($urandom % 100) < 60;
            step  = ($urandom % 100) < 35;
            run();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule